// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows the power-management state of one processor core and turns it into clock-gating and operating-point requests. Idle requests from software move the core from running into halt. A stop-clock request from the platform moves it into stop-grant, where the block still answers snoops. Sleep and deep-sleep requests then gate progressively more of the clock tree. When the extended mode is enabled, the block first asks an external regulator agent for a low frequency and voltage point and waits for its acknowledge before it settles. On the way back it asks for the normal point again and waits for that acknowledge too.

Power-on configuration straps are latched once when reset is released. The PLL relock wait after deep sleep is set by an input count. Any activity on inputs that must stay quiet during sleep is reported on a protocol-error pulse.

Top module: `cpu_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is sampled low from any state including sleep, the block shows state 0 (running) with `core_clk_en`=1, `pll_en`=1, `lowop_req`=0, `snoop_done`=0 and `proto_err`=0.
- R2: In state 0, `halt_req` moves the block to state 1 (halt) at the next edge. If `stopclk_req` is high in the same cycle, it takes priority.
- R3: In state 1, any set bit of `wake_evt` returns the block to state 0 at the next edge, even if `stopclk_req` is high.
- R4: With `ext_en` low, `stopclk_req` in state 0 or 1 enters state 2 (stop-grant). When `stopclk_req` drops in state 2, the block returns to the state it came from (0 or 1).
- R5: When `snoop_req` is sampled high in state 2, `snoop_done` is high for exactly the following cycle, and the state stays 2.
- R6: With `ext_en` high, `stopclk_req` in state 0 or 1 enters state 5 (lowering), which raises `lowop_req`. State 2 is reached only on the edge after `lowop_ack` is sampled high. `lowop_req` stays high in states 2, 3, 4 and 6 entered this way.
- R7: When `stopclk_req` drops in state 2 or state 5 after an extended entry, the block goes to state 7 (raising) with `lowop_req` low. It returns to the originating state 0 or 1 only on the edge after `lowop_ack` is sampled low.
- R8: `sleep_req` in state 2 enters state 3 (sleep), where `core_clk_en`=0 and `pll_en`=1. Dropping `sleep_req` in state 3 returns to state 2. `sleep_req` has no effect in any other state.
- R9: `dsleep_req` in state 3 enters state 4 (deep sleep) with `pll_en`=0. Dropping it enters state 6 (relock) with `pll_en`=1. The block stays in state 6 for exactly N+1 cycles, where N is `lock_cycles`, then returns to state 3.
- R10: In state 3, a change in any of `halt_req`, `wake_evt`, `stopclk_req`, `snoop_req`, `ext_en` or `lowop_ack` from the previous cycle raises `proto_err` for the next cycle. Changes on `sleep_req`, `dsleep_req` and `rst_n` raise no flag.
- R11: `strap_q` takes `strap_in` on the first edge at which `rst_n` is high after being low, and holds that value until the next reset.
- R12: `core_clk_en` is high only in states 0, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also a wake event |
| halt_req | input | 1 | Halt or monitor-wait request |
| wake_evt | input | NWAKE | Interrupt, NMI, SMI and init events |
| stopclk_req | input | 1 | Platform stop-clock request |
| sleep_req | input | 1 | Sleep request |
| dsleep_req | input | 1 | Deep-sleep request |
| snoop_req | input | 1 | Snoop arriving in stop-grant |
| ext_en | input | 1 | Extended low-point mode enable |
| lowop_ack | input | 1 | Operating-point agent acknowledge level |
| lock_cycles | input | LOCK_W | PLL relock wait count N |
| strap_in | input | STRAP_W | Configuration strap pins |
| pwr_state | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| lowop_req | output | 1 | Low operating point request level |
| snoop_done | output | 1 | Snoop serviced pulse |
| proto_err | output | 1 | Input activity during sleep |
| strap_q | output | STRAP_W | Latched straps |

## Verification
The bench builds the block with `LOCK_W`=3 and `STRAP_W`=4. With those widths, both the zero relock count and the largest count of 7 fit in short runs, and distinct strap patterns can tell a fresh capture from a held value. The reference model tracks every state and output each cycle. Directed steps cover the two acknowledge waits with the acknowledge held, reset taken from sleep, and the wake-over-stop-clock priority.

// File: rtl/cpu_pwr_seq.sv
module cpu_pwr_seq #(
  parameter int STRAP_W = 4,
  parameter int LOCK_W  = 8,
  parameter int NWAKE   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic [NWAKE-1:0]   wake_evt,
  input  logic               stopclk_req,
  input  logic               sleep_req,
  input  logic               dsleep_req,
  input  logic               snoop_req,
  input  logic               ext_en,
  input  logic               lowop_ack,
  input  logic [LOCK_W-1:0]  lock_cycles,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [2:0]         pwr_state,
  output logic               core_clk_en,
  output logic               pll_en,
  output logic               lowop_req,
  output logic               snoop_done,
  output logic               proto_err,
  output logic [STRAP_W-1:0] strap_q
);
  localparam int WATCH_W = NWAKE + 5;

  typedef enum logic [2:0] {
    S_RUN = 3'd0, S_HALT = 3'd1, S_GRANT = 3'd2, S_SLP = 3'd3,
    S_DEEP = 3'd4, S_LOWER = 3'd5, S_RELOCK = 3'd6, S_RAISE = 3'd7
  } pst_t;

  pst_t st, nxt, orig;
  logic ext_q, ext_nxt, load_orig, rst_d;
  logic [LOCK_W-1:0] cnt, cnt_nxt;
  logic [WATCH_W-1:0] watch, watch_q;

  assign watch = {halt_req, wake_evt, stopclk_req, snoop_req, ext_en, lowop_ack};

  always_comb begin
    nxt = st;
    cnt_nxt = cnt;
    ext_nxt = ext_q;
    load_orig = 1'b0;
    case (st)
      S_RUN, S_HALT: begin
        if (st == S_HALT && |wake_evt) nxt = S_RUN;
        else if (stopclk_req) begin
          load_orig = 1'b1;
          if (ext_en) begin
            nxt = S_LOWER;
            ext_nxt = 1'b1;
          end else nxt = S_GRANT;
        end else if (st == S_RUN && halt_req) nxt = S_HALT;
      end
      S_LOWER: begin
        if (!stopclk_req) nxt = S_RAISE;
        else if (lowop_ack) nxt = S_GRANT;
      end
      S_GRANT: begin
        if (!stopclk_req) nxt = ext_q ? S_RAISE : orig;
        else if (sleep_req) nxt = S_SLP;
      end
      S_SLP: begin
        if (dsleep_req) nxt = S_DEEP;
        else if (!sleep_req) nxt = S_GRANT;
      end
      S_DEEP: begin
        if (!dsleep_req) begin
          nxt = S_RELOCK;
          cnt_nxt = lock_cycles;
        end
      end
      S_RELOCK: begin
        if (cnt == '0) nxt = S_SLP;
        else cnt_nxt = cnt - 1'b1;
      end
      S_RAISE: begin
        if (!lowop_ack) begin
          nxt = orig;
          ext_nxt = 1'b0;
        end
      end
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RUN;
      orig <= S_RUN;
      ext_q <= 1'b0;
      cnt <= '0;
      snoop_done <= 1'b0;
      proto_err <= 1'b0;
      watch_q <= '0;
      rst_d <= 1'b0;
    end else begin
      st <= nxt;
      if (load_orig) orig <= st;
      ext_q <= ext_nxt;
      cnt <= cnt_nxt;
      snoop_done <= (st == S_GRANT) && snoop_req;
      proto_err <= (st == S_SLP) && (watch != watch_q);
      watch_q <= watch;
      rst_d <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !rst_d) strap_q <= strap_in;
  end

  assign pwr_state   = st;
  assign core_clk_en = (st == S_RUN) || (st == S_LOWER) || (st == S_RAISE);
  assign pll_en      = (st != S_DEEP);
  assign lowop_req   = (st == S_LOWER) ||
                       (ext_q && (st == S_GRANT || st == S_SLP || st == S_DEEP || st == S_RELOCK));

  assert_sleep_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLP && $past(st) != S_SLP) |-> ($past(st) == S_GRANT || $past(st) == S_RELOCK));

  assert_deep_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEEP && $past(st) != S_DEEP) |-> $past(st) == S_SLP);

  assert_low_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GRANT && $past(st) == S_LOWER) |-> $past(lowop_ack));

  assert_raise_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_RUN || st == S_HALT) && $past(st) == S_RAISE) |-> !$past(lowop_ack));

  assert_strap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_d |=> $stable(strap_q));
endmodule

// File: tb/cpu_pwr_seq_test.sv
module cpu_pwr_seq_test;
  logic clk = 0, rst_n = 0;
  logic halt_req = 0, stopclk_req = 0, sleep_req = 0, dsleep_req = 0;
  logic snoop_req = 0, ext_en = 0, lowop_ack = 0;
  logic [3:0] wake_evt = 0, strap_in = 0, strap_q;
  logic [2:0] lock_cycles = 0, pwr_state;
  logic core_clk_en, pll_en, lowop_req, snoop_done, proto_err;
  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;

  always #10 clk = ~clk;

  cpu_pwr_seq #(.STRAP_W(4), .LOCK_W(3), .NWAKE(4)) uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake_evt(wake_evt),
    .stopclk_req(stopclk_req), .sleep_req(sleep_req), .dsleep_req(dsleep_req),
    .snoop_req(snoop_req), .ext_en(ext_en), .lowop_ack(lowop_ack),
    .lock_cycles(lock_cycles), .strap_in(strap_in), .pwr_state(pwr_state),
    .core_clk_en(core_clk_en), .pll_en(pll_en), .lowop_req(lowop_req),
    .snoop_done(snoop_done), .proto_err(proto_err), .strap_q(strap_q));

  // behavioural reference
  int ms = 0, morig = 0, mcnt = 0;
  bit mext = 0, msd = 0, mpe = 0, mseen = 0;
  bit [8:0] mprev = 0;
  bit [3:0] mstrap = 0;

  always @(posedge clk) begin
    bit [8:0] w;
    int n;
    w = {halt_req, wake_evt, stopclk_req, snoop_req, ext_en, lowop_ack};
    if (!rst_n) begin
      ms = 0; morig = 0; mext = 0; mcnt = 0; msd = 0; mpe = 0; mprev = 0; mseen = 0;
    end else begin
      if (!mseen) mstrap = strap_in;
      mseen = 1;
      msd = (ms == 2) && snoop_req;
      mpe = (ms == 3) && (w != mprev);
      mprev = w;
      n = ms;
      if (ms <= 1) begin
        if (ms == 1 && wake_evt != 0) n = 0;
        else if (stopclk_req) begin morig = ms; n = ext_en ? 5 : 2; if (ext_en) mext = 1; end
        else if (ms == 0 && halt_req) n = 1;
      end else if (ms == 5) n = !stopclk_req ? 7 : (lowop_ack ? 2 : 5);
      else if (ms == 2) begin
        if (!stopclk_req) n = mext ? 7 : morig;
        else if (sleep_req) n = 3;
      end else if (ms == 3) n = dsleep_req ? 4 : (sleep_req ? 3 : 2);
      else if (ms == 4) begin if (!dsleep_req) begin n = 6; mcnt = lock_cycles; end end
      else if (ms == 6) begin if (mcnt == 0) n = 3; else mcnt--; end
      else if (ms == 7) begin if (!lowop_ack) begin n = morig; mext = 0; end end
      ms = n;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R1"; 1: return "R2"; 2: return "R4"; 3: return "R8";
      4: return "R9"; 5: return "R6"; 6: return "R9"; default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started) begin
      bit [6:0] act, exp;
      act = {pwr_state, core_clk_en, pll_en, lowop_req, snoop_done};
      exp = {3'(ms), (ms == 0 || ms == 5 || ms == 7), ms != 4,
             (ms == 5) || (mext && (ms == 2 || ms == 3 || ms == 4 || ms == 6)), msd};
      checks++;
      if (act != exp || proto_err != mpe) begin
        fails++;
        $display("FAIL %s model: got %b/%b expected %b/%b", tag_of(ms), act, proto_err, exp, mpe);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        fails++; checks++;
        $display("FAIL watchdog: got %0d expected below 5000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    strap_in = 4'hA;
    lock_cycles = 3;
    tick(3);
    started = 1;
    chk("R1", pwr_state, 0); chk("R1", pll_en, 1); chk("R1", lowop_req, 0);
    rst_n = 1; tick;
    chk("R11", strap_q, 4'hA);
    strap_in = 4'h5; tick(3);
    chk("R11", strap_q, 4'hA);

    halt_req = 1; tick; chk("R2", pwr_state, 1); chk("R12", core_clk_en, 0);
    halt_req = 0; wake_evt = 4'b0100; tick; chk("R3", pwr_state, 0);
    wake_evt = 0; halt_req = 1; tick; halt_req = 0;
    stopclk_req = 1; wake_evt = 4'b0001; tick; chk("R3", pwr_state, 0);
    wake_evt = 0; tick; chk("R2", pwr_state, 2);
    stopclk_req = 0; tick; chk("R4", pwr_state, 0);
    halt_req = 1; tick; halt_req = 0;
    stopclk_req = 1; tick; chk("R4", pwr_state, 2);
    snoop_req = 1; tick; chk("R5", pwr_state, 2); chk("R5", snoop_done, 1);
    snoop_req = 0; tick; chk("R5", snoop_done, 0);

    sleep_req = 1; tick; chk("R8", pwr_state, 3); chk("R8", core_clk_en, 0); chk("R8", pll_en, 1);
    dsleep_req = 1; tick; chk("R9", pwr_state, 4); chk("R9", pll_en, 0); chk("R10", proto_err, 0);
    dsleep_req = 0; tick; chk("R9", pwr_state, 6); chk("R9", pll_en, 1);
    for (int i = 0; i < 3; i++) begin tick; chk("R9", pwr_state, 6); end
    tick; chk("R9", pwr_state, 3);
    snoop_req = 1; tick; chk("R10", proto_err, 1); chk("R10", snoop_done, 0);
    tick; chk("R10", proto_err, 0);
    snoop_req = 0; tick; chk("R10", proto_err, 1);
    lock_cycles = 0; tick;
    dsleep_req = 1; tick; dsleep_req = 0; tick; chk("R9", pwr_state, 6);
    tick; chk("R9", pwr_state, 3);
    sleep_req = 0; tick; chk("R8", pwr_state, 2);
    stopclk_req = 0; tick; chk("R4", pwr_state, 1);
    wake_evt = 4'b1000; tick; chk("R3", pwr_state, 0); wake_evt = 0;
    sleep_req = 1; tick(2); chk("R8", pwr_state, 0); sleep_req = 0;

    ext_en = 1; stopclk_req = 1; tick;
    chk("R6", pwr_state, 5); chk("R6", lowop_req, 1); chk("R12", core_clk_en, 1);
    tick(3); chk("R6", pwr_state, 5);
    lowop_ack = 1; tick; chk("R6", pwr_state, 2); chk("R6", lowop_req, 1);
    sleep_req = 1; tick; chk("R6", lowop_req, 1);
    rst_n = 0; strap_in = 4'h3; tick;
    chk("R1", pwr_state, 0); chk("R1", lowop_req, 0); chk("R11", strap_q, 4'hA);
    sleep_req = 0; stopclk_req = 0; lowop_ack = 0; ext_en = 0;
    rst_n = 1; tick; chk("R11", strap_q, 4'h3);

    ext_en = 1; stopclk_req = 1; tick; lowop_ack = 1; tick; chk("R6", pwr_state, 2);
    stopclk_req = 0; tick; chk("R7", pwr_state, 7); chk("R7", lowop_req, 0);
    tick(2); chk("R7", pwr_state, 7);
    lowop_ack = 0; tick; chk("R7", pwr_state, 0);
    halt_req = 1; tick; halt_req = 0;
    stopclk_req = 1; tick; chk("R6", pwr_state, 5);
    stopclk_req = 0; tick; chk("R7", pwr_state, 7);
    tick; chk("R7", pwr_state, 1);
    tick(2);
    started = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule